// File: doc/BRIEF.md
# Countdown Tick Timer

This block is a single-channel event timer for a system tick. Software arms it by programming a start count. On each cycle that the external tick-enable input is high, the count drops by one. When the count runs out, a pending flag is raised and can drive a level interrupt. All configuration goes through a small register read/write port with two mapped words: a control word and a count word.

One run bit in the control word gates three things: counting, acceptance of new counts, and changes to the interrupt permission. Writing the count word is itself the start command, so there is no separate go bit. The pending flag stays set until software writes a self-clearing clear bit in the control word. The interrupt output is the pending flag masked by the run and permission bits, and it is registered.

Top module: `cdn_tick_timer`

## Requirements
- R1: After synchronous reset the control word reads 0, the count word reads 0 and `irq_o` is 0.
- R2: The control word is at address 0x40. Bit 0 is the run bit and bit 1 is the interrupt permission bit. Bit 4 is a write-only clear strobe that reads back as 0. All other control bits read as 0.
- R3: A write to address 0x44 while the run bit is 1 loads the written count and starts the countdown. A read of 0x44 returns the remaining count.
- R4: While the run bit is 1 and a count is active, the count decreases by exactly one on each cycle in which `tick_en_i` is high. It does not change on cycles where `tick_en_i` is low.
- R5: The pending flag is set in the cycle after the count reaches 0. Counting then stops, and the count holds at 0 until a new count is written.
- R6: `irq_o` is a register that follows pending AND permission AND run, one cycle late. Pending still held while the mask is closed appears on `irq_o` once the mask opens.
- R7: Writing 1 to control bit 4 clears the pending flag. If an expiry happens in the same cycle as the clear, the expiry wins and the flag stays set.
- R8: A count write made while the run bit is 0 is ignored, and the count keeps its old value.
- R9: A change to the permission bit written while the run bit is 0 is ignored. Writing 0 to the control word clears both the run bit and the permission bit.
- R10: Clearing the run bit freezes the count. Setting it again resumes the countdown from the frozen value.
- R11: Loading a count of 0 raises the pending flag in the next cycle, without needing any tick.
- R12: Read data appears on `rdata_o` in the cycle after `rd_en_i`. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | Count-down qualifier, one decrement per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (8) | Register byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench aims at the gating corners. It writes a count and the permission bit while the run bit is low, where a design that let them through would start counting or raise an interrupt while disabled. It times expiry to the exact cycle, including a zero count, so an off-by-one counter or a missing pipeline stage shows up as the interrupt appearing one cycle early or late. It also lands a clear strobe on the same cycle as an expiry, and holds a pending flag behind a closed mask. A design that gave the clear priority, or dropped pending when the control word was zeroed, would lose that interrupt.

// File: rtl/cdn_tick_pkg.sv
package cdn_tick_pkg;
  // control bit positions that software encodes directly
  localparam int RUN_BIT   = 0;
  localparam int ALLOW_BIT = 1;
  localparam int CLR_BIT   = 4;

  typedef struct packed {
    logic allow;
    logic run;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_VAL  = 2'd2
  } rsel_e;
endpackage

// File: rtl/cdn_bus_decode.sv
module cdn_bus_decode
  import cdn_tick_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ctrl_wr_o,
  output logic              val_wr_o,
  output rsel_e             rsel_o
);
  logic hit_ctrl, hit_val;

  always_comb begin
    hit_ctrl  = (addr_i == CTRL_OFS);
    hit_val   = (addr_i == VAL_OFS);
    ctrl_wr_o = wr_en_i & hit_ctrl;
    val_wr_o  = wr_en_i & hit_val;
    if (!rd_en_i)      rsel_o = SEL_NONE;
    else if (hit_ctrl) rsel_o = SEL_CTRL;
    else if (hit_val)  rsel_o = SEL_VAL;
    else               rsel_o = SEL_NONE;
  end
endmodule

// File: rtl/cdn_ctrl_regs.sv
module cdn_ctrl_regs
  import cdn_tick_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  ctrl_wr_i,
  input  logic  wr_run_i,
  input  logic  wr_allow_i,
  input  logic  wr_clr_i,
  output ctrl_t ctrl_o,
  output logic  clr_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_i) begin
      ctrl_q.run <= wr_run_i;
      // permission only moves while running; a run=0 write drops it
      if (!wr_run_i)       ctrl_q.allow <= 1'b0;
      else if (ctrl_q.run) ctrl_q.allow <= wr_allow_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign clr_o  = ctrl_wr_i & wr_clr_i;

  // R9: permission never stands without the run bit
  p_allow_needs_run_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    ctrl_q.allow |-> ctrl_q.run);

  // R9: a disabled write cannot open the permission bit
  p_allow_ignored_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_wr_i && !ctrl_q.run) |=> !ctrl_q.allow);
endmodule

// File: rtl/cdn_down_counter.sv
module cdn_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             active_q;
  logic             at_zero;

  assign at_zero  = (count_q == '0);
  assign expire_o = run_i & active_q & at_zero & ~load_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q  <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      count_q  <= load_val_i;
      active_q <= 1'b1;
    end else if (expire_o) begin
      active_q <= 1'b0;
    end else if (run_i && active_q && tick_i && !at_zero) begin
      count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;

  // R5: a spent count holds at zero until reloaded
  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (at_zero && !load_i) |=> (count_q == '0));

  // R10: no movement while the run bit is low
  p_frozen_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_i && !load_i) |=> $stable(count_q));

  // R4: at most one step per cycle
  p_single_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !at_zero) |=> (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/cdn_irq_flag.sv
module cdn_irq_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic run_i,
  input  logic allow_i,
  output logic irq_o
);
  logic pend_q;
  logic irq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (set_i)      pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
      irq_q <= pend_q & allow_i & run_i;
    end
  end

  assign irq_o = irq_q;

  // R7: expiry beats a clear in the same cycle
  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> pend_q);

  // R7: a lone clear drops the flag
  p_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !pend_q);

  // R6: output only follows an open mask
  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q |-> $past(run_i && allow_i && pend_q));
endmodule

// File: rtl/cdn_tick_timer.sv
module cdn_tick_timer
  import cdn_tick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_en_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CTRL_RD_W = ALLOW_BIT + 1;

  logic             ctrl_wr, val_wr, clr, expire;
  rsel_e            rsel;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] count;
  logic [DATA_W-1:0] rdata_q;

  cdn_bus_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .VAL_OFS(VAL_OFS)) u_dec (
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .ctrl_wr_o (ctrl_wr),
    .val_wr_o  (val_wr),
    .rsel_o    (rsel)
  );

  cdn_ctrl_regs u_ctrl (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ctrl_wr_i  (ctrl_wr),
    .wr_run_i   (wdata_i[RUN_BIT]),
    .wr_allow_i (wdata_i[ALLOW_BIT]),
    .wr_clr_i   (wdata_i[CLR_BIT]),
    .ctrl_o     (ctrl),
    .clr_o      (clr)
  );

  cdn_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .run_i      (ctrl.run),
    .tick_i     (tick_en_i),
    .load_i     (val_wr & ctrl.run),
    .load_val_i (CNT_W'(wdata_i)),
    .count_o    (count),
    .expire_o   (expire)
  );

  cdn_irq_flag u_irq (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .set_i   (expire),
    .clr_i   (clr),
    .run_i   (ctrl.run),
    .allow_i (ctrl.allow),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else begin
      case (rsel)
        SEL_CTRL: rdata_q <= DATA_W'({ctrl.allow, ctrl.run});
        SEL_VAL:  rdata_q <= DATA_W'(count);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  // R8: a disabled count write leaves the count alone
  p_val_ignored_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (val_wr && !ctrl.run) |=> $stable(count));

  // R2: control readback never shows bits above the permission bit
  p_ctrl_rd_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (rsel == SEL_CTRL) |=> (rdata_q >> CTRL_RD_W) == '0);
endmodule

// File: tb/sim_cdn_tick_timer.sv
module sim_cdn_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_VAL  = 8'h44;

  always #2.5 clk = ~clk;

  cdn_tick_timer u0 (
    .clk_i(clk), .rst_i(rst), .tick_en_i(tick), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'd0, irq}, 0);
    rreg(A_CTRL, d); chk("R1 ctrl", d, 0);
    rreg(A_VAL, d);  chk("R1 val", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wreg(A_CTRL, 32'h13); rreg(A_CTRL, d); chk("R9 allow ignored when off", d, 32'h1);
    wreg(A_CTRL, 32'h3);  rreg(A_CTRL, d); chk("R2 run+allow", d, 32'h3);
    wreg(A_CTRL, 32'hFFFF_FFFF); rreg(A_CTRL, d); chk("R2 other bits zero", d, 32'h3);
    wreg(A_CTRL, 32'h0);  rreg(A_CTRL, d); chk("R9 zero write", d, 32'h0);
    rreg(8'h48, d); chk("R12 unmapped", d, 0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wreg(A_CTRL, 32'h1);
    wreg(A_VAL, 32'd100); rreg(A_VAL, d); chk("R3 load", d, 32'd100);
    tick = 1'b1; idle(3); tick = 1'b0;
    rreg(A_VAL, d); chk("R4 three ticks", d, 32'd97);
    idle(4); rreg(A_VAL, d); chk("R4 no tick no change", d, 32'd97);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    wreg(A_CTRL, 32'h0);
    tick = 1'b1; idle(5); tick = 1'b0;
    rreg(A_VAL, d); chk("R10 frozen", d, 32'd97);
    wreg(A_VAL, 32'd5); rreg(A_VAL, d); chk("R8 write ignored", d, 32'd97);
    wreg(A_CTRL, 32'h1);
    tick = 1'b1; idle(2); tick = 1'b0;
    rreg(A_VAL, d); chk("R10 resume", d, 32'd95);
  endtask

  task automatic t_expire();
    logic [31:0] d;
    wreg(A_CTRL, 32'h13);
    tick = 1'b1;
    wreg(A_VAL, 32'd4);
    idle(5); chk("R6 irq not yet", {31'd0, irq}, 0);
    idle(1); chk("R5 irq at expiry", {31'd0, irq}, 1);
    idle(3); rreg(A_VAL, d); chk("R5 holds zero", d, 0);
    tick = 1'b0;
    wreg(A_CTRL, 32'h13);
    idle(1); chk("R7 cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_mask();
    wreg(A_CTRL, 32'h1);
    tick = 1'b1; wreg(A_VAL, 32'd2); idle(6); tick = 1'b0;
    chk("R6 masked", {31'd0, irq}, 0);
    wreg(A_CTRL, 32'h3); idle(1);
    chk("R6 unmask shows pending", {31'd0, irq}, 1);
    wreg(A_CTRL, 32'h0); idle(1);
    chk("R9 zero ctrl masks irq", {31'd0, irq}, 0);
    wreg(A_CTRL, 32'h1); wreg(A_CTRL, 32'h3); idle(1);
    chk("R6 pending kept", {31'd0, irq}, 1);
    wreg(A_CTRL, 32'h13); idle(1);
    chk("R7 clear", {31'd0, irq}, 0);
  endtask

  task automatic t_zero();
    wreg(A_CTRL, 32'h3);
    wreg(A_VAL, 32'd0);
    idle(1); chk("R11 not before", {31'd0, irq}, 0);
    idle(1); chk("R11 zero load fires", {31'd0, irq}, 1);
    wreg(A_CTRL, 32'h13); idle(1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wreg(A_CTRL, 32'h13);
    tick = 1'b1;
    wreg(A_VAL, 32'd2);
    idle(2);
    wreg(A_CTRL, 32'h13);
    idle(1); chk("R7 set wins", {31'd0, irq}, 1);
    tick = 1'b0;
    rreg(A_VAL, d); chk("R5 zero after collide", d, 0);
    wreg(A_CTRL, 32'h13); idle(1);
    chk("R7 later clear", {31'd0, irq}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_load();
    t_freeze();
    t_expire();
    t_mask();
    t_zero();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule